// File: doc/BRIEF.md
# Pin Data and Direction Register Group

This block is a bank of general-purpose I/O control registers for a group of pins (32 by default) on a simple synchronous register bus. The bus has a word address, a write enable, write data and read data. Software sets each pin's direction through a direction register. In that register a 1 means the pin is an input and a 0 means it is an output. The block drives the output enable of each pin as the inverse of that bit.

The output value latch has no direct write path. Software changes it only with masks. Writing a mask to the set register raises every latch bit whose mask bit is 1. Writing a mask to the clear register lowers every latch bit whose mask bit is 1. All other latch bits keep their value. Software therefore never needs a read-modify-write to change the outputs.

The raw pin levels pass through a two-stage synchronizer. The result is readable at the input register, whatever the direction of each pin. A level that is read right after a set or clear may still be the old one. The pins are organised as independent 16-pin banks. Pins 0 to 15 form the lower bank and pins 16 to 31 form the upper bank.

Top module: `gpio_dio`

## Requirements
- R1: While the reset is held low and after it is released, every direction bit is 1, pin_oe is all zeros, the output latch (pin_out) is all zeros and the input register reads 0.
- R2: A write to word address 0 loads the direction register from bus_wdata. Address 0 reads back the stored value. The next cycle pin_oe equals the bitwise inverse of the direction register, where bit 1 means input and bit 0 means output.
- R3: A write to word address 1 sets to 1 every latch bit whose bus_wdata bit is 1 and leaves the other bits unchanged. pin_out shows the new latch value from the cycle after the write.
- R4: A write to word address 2 clears to 0 every latch bit whose bus_wdata bit is 1 and leaves the other bits unchanged. pin_out shows the new latch value from the cycle after the write.
- R5: Reads of word address 1 and of word address 2 both return the current output latch value.
- R6: Word address 3 returns the level that pin_in had two clock edges earlier, through a two-flop synchronizer. This holds for pins configured as inputs and for pins configured as outputs.
- R7: Every address with a nonzero bit above bit 1 reads 0. A write to such an address changes neither the direction register nor the latch.
- R8: A write to word address 3 (the input register) changes neither the direction register nor the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and synchronizer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (4) | Word address of the register accessed |
| bus_we | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | PINS (32) | Write data or mask |
| bus_rdata | output | PINS (32) | Combinational read data for bus_addr |
| pin_in | input | PINS (32) | Raw, asynchronous pin levels |
| pin_out | output | PINS (32) | Output value latch, one bit per pin |
| pin_oe | output | PINS (32) | Output enable per pin, 1 means drive |

## Verification
The set and clear masks are tested with several patterns:
- masks that overlap bits already set, which separates a true read-modify-write from a plain overwrite;
- masks confined to one bank, which exposes any coupling between the lower and upper bank;
- pseudo-random masks, which check that untouched bits are really preserved.

The input register is exercised with walking-one, all-ones and random pin patterns. Some of these run while the same pins are outputs, which shows both the two-edge delay and the independence from direction. Writes to the input register and to unmapped addresses, carrying all-ones data, check that no state moves when it should not. A cycle-accurate model compares pin_out, pin_oe and the read data on every cycle.

// File: rtl/gpio_dio_pkg.sv
// Package: shared register selector and bank geometry for the pin register group.
// Assumes word addressing with the two low address bits selecting a register.
package gpio_dio_pkg;
    localparam int unsigned BANK_W = 16;
    localparam int unsigned SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR = 2'd0,
        SEL_SET = 2'd1,
        SEL_CLR = 2'd2,
        SEL_IN  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_dio_sync.sv
// Module: multi-stage level synchronizer for raw pin inputs.
// Assumes the inputs are asynchronous and need no glitch filtering. Reset clears all stages.
module gpio_dio_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw levels in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_q[0] <= '0;
                    else        stg_q[0] <= raw_i;
                end
            end else begin : g_next
                // Shift the value on through the later stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_dio_decode.sv
// Module: address decoder turning a bus write into per-register strobes.
// Assumes the upper address bits must all be zero for a register to be hit.
module gpio_dio_decode
    import gpio_dio_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit_o,
    output reg_sel_e          sel_o,
    output logic              wr_dir_o,
    output logic              wr_set_o,
    output logic              wr_clr_o
);
    localparam int unsigned HI_W = ADDR_W - SEL_W;

    // Decide whether the address hits a register, and which one.
    always_comb begin
        hit_o = (bus_addr[ADDR_W-1:SEL_W] == {HI_W{1'b0}});
        sel_o = reg_sel_e'(bus_addr[SEL_W-1:0]);
    end

    // Produce one write strobe per writable register; the input register takes none.
    always_comb begin
        wr_dir_o = bus_we && hit_o && (sel_o == SEL_DIR);
        wr_set_o = bus_we && hit_o && (sel_o == SEL_SET);
        wr_clr_o = bus_we && hit_o && (sel_o == SEL_CLR);
    end
endmodule

// File: rtl/gpio_dio_bank.sv
// Module: one bank of pins, holding direction bits, the output latch and the input synchronizer.
// Assumes at most one of the set and clear strobes is active per cycle. If both are, clear dominates.
module gpio_dio_bank #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] in_q
);
    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    // Form the set and clear masks from the strobes.
    always_comb begin
        set_m = wr_set ? wdata : '0;
        clr_m = wr_clr ? wdata : '0;
    end

    // Hold the direction bits; reset makes every pin an input.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (wr_dir) dir_q <= wdata;
    end

    // Update the output latch through the masks only, with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= (lat_q | set_m) & ~clr_m;
    end

    gpio_dio_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_raw),
        .sync_o (in_q)
    );
endmodule

// File: rtl/gpio_dio.sv
// Module: top of the pin data and direction register group.
// Splits the pins into banks, decodes bus writes and returns read data combinationally.
// Assumes PINS is a multiple of the bank width and ADDR_W is larger than the selector width.
module gpio_dio
    import gpio_dio_pkg::*;
#(
    parameter int unsigned PINS        = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    localparam int unsigned NBANK = PINS / BANK_W;

    logic            hit;
    reg_sel_e        sel;
    logic            wr_dir;
    logic            wr_set;
    logic            wr_clr;
    logic [PINS-1:0] dir_all;
    logic [PINS-1:0] lat_all;
    logic [PINS-1:0] in_all;

    gpio_dio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .hit_o    (hit),
        .sel_o    (sel),
        .wr_dir_o (wr_dir),
        .wr_set_o (wr_set),
        .wr_clr_o (wr_clr)
    );

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            gpio_dio_bank #(.W(BANK_W), .STAGES(SYNC_STAGES)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_dir  (wr_dir),
                .wr_set  (wr_set),
                .wr_clr  (wr_clr),
                .wdata   (bus_wdata[b*BANK_W +: BANK_W]),
                .pin_raw (pin_in[b*BANK_W +: BANK_W]),
                .dir_q   (dir_all[b*BANK_W +: BANK_W]),
                .lat_q   (lat_all[b*BANK_W +: BANK_W]),
                .in_q    (in_all[b*BANK_W +: BANK_W])
            );
        end
    endgenerate

    // Drive the pins: the latch value, and an enable that is the inverse of direction.
    always_comb begin
        pin_out = lat_all;
        pin_oe  = ~dir_all;
    end

    // Select the read data; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_DIR:          bus_rdata = dir_all;
                SEL_SET, SEL_CLR: bus_rdata = lat_all;
                SEL_IN:           bus_rdata = in_all;
                default:          bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_dio_chk.sv
// Module: assertion checker for gpio_dio, attached by bind. It observes ports only.
// Assumes the default register map (two selector bits) and a two-stage synchronizer.
module gpio_dio_chk #(
    parameter int unsigned PINS   = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pin_in,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe
);
    logic [1:0] since_rst;
    logic       hi_zero;

    assign hi_zero = (bus_addr[ADDR_W-1:2] == '0);

    // Count the cycles since reset, saturating at two, to gate the synchronizer check.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

    a_r2_dir_vs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_zero && bus_addr[1:0] == 2'd0) |-> (bus_rdata == ~pin_oe));

    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hi_zero && bus_addr[1:0] == 2'd1) |=>
        ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_set_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hi_zero && bus_addr[1:0] == 2'd1) |=>
        ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

    a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hi_zero && bus_addr[1:0] == 2'd2) |=>
        ((pin_out & $past(bus_wdata)) == '0));

    a_r5_latch_read: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_zero && (bus_addr[1:0] == 2'd1 || bus_addr[1:0] == 2'd2)) |-> (bus_rdata == pin_out));

    a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && hi_zero && bus_addr[1:0] == 2'd3) |-> (bus_rdata == $past(pin_in, 2)));

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_zero) |-> (bus_rdata == '0));

    a_r8_in_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (!hi_zero || bus_addr[1:0] == 2'd3)) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_dio gpio_dio_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_dio_tb_top.sv
// Bench: drives gpio_dio at the falling edge and compares it with a behavioural model every cycle.
module gpio_dio_tb_top;
    localparam int PINS = 32;
    localparam int AW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [PINS-1:0] bus_wdata = '0;
    logic [PINS-1:0] bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out;
    logic [PINS-1:0] pin_oe;

    int tests = 0;
    int fails = 0;

    // Behavioural model state.
    logic [31:0] m_dir, m_lat;
    logic [31:0] m_pins [$];

    always #4 clk = ~clk;

    gpio_dio dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Model update: the register effects of each write, plus a history of sampled pin levels.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '1;
            m_lat = '0;
            m_pins = {32'h0, 32'h0};
        end else begin
            if (bus_we && bus_addr[AW-1:2] == 0) begin
                case (bus_addr[1:0])
                    2'd0: m_dir = bus_wdata;
                    2'd1: m_lat = m_lat | bus_wdata;
                    2'd2: m_lat = m_lat & ~bus_wdata;
                    default: ;
                endcase
            end
            m_pins.push_back(pin_in);
            void'(m_pins.pop_front());
        end
    end

    function automatic logic [31:0] exp_rd();
        if (bus_addr[AW-1:2] != 0) return 32'h0;
        case (bus_addr[1:0])
            2'd0: return m_dir;
            2'd3: return m_pins[0];
            default: return m_lat;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rd_tag();
        if (!rst_n) return "R1 read";
        if (bus_addr[AW-1:2] != 0) return "R7 unmapped read";
        case (bus_addr[1:0])
            2'd0: return "R2 direction read";
            2'd3: return "R6 input read";
            default: return "R5 latch read";
        endcase
    endfunction

    // One cycle: compare the current outputs with the model, then apply the next inputs.
    task automatic step(input logic we, input logic [AW-1:0] a, input logic [31:0] d, input logic [31:0] p);
        @(negedge clk);
        check(rst_n ? "R2 pin_oe" : "R1 pin_oe", pin_oe, ~m_dir);
        check(rst_n ? "R3/R4 pin_out" : "R1 pin_out", pin_out, m_lat);
        check(rd_tag(), bus_rdata, exp_rd());
        bus_we = we; bus_addr = a; bus_wdata = d; pin_in = p;
    endtask

    logic [31:0] lfsr = 32'h1234_5678;
    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin : main
        logic [31:0] held_lat, held_dir;
        step(0, 4'd0, 0, 32'hFFFF_FFFF);
        step(0, 4'd3, 0, 32'hFFFF_FFFF);
        step(0, 4'd1, 0, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        step(0, 4'd3, 0, 32'h0);
        // R2: lower bank to outputs
        step(1, 4'd0, 32'h0000_FFFF, 32'h0);
        step(0, 4'd0, 0, 32'h0);
        // R3: set, overlapping set, upper-bank-only set
        step(1, 4'd1, 32'hA5A5_00FF, 32'h0);
        step(1, 4'd1, 32'h0F0F_0F0F, 32'h0);
        step(1, 4'd1, 32'h8000_0000, 32'h0);
        step(0, 4'd2, 0, 32'h0);
        // R4: clear, lower-bank-only clear
        step(1, 4'd2, 32'h0000_000F, 32'h0);
        step(1, 4'd2, 32'h0000_FFFF, 32'h0);
        step(0, 4'd1, 0, 32'h0);
        // R6: walking one on the pins while reading the input register
        for (int i = 0; i < 32; i++) step(0, 4'd3, 0, 32'h1 << i);
        step(0, 4'd3, 0, 32'hFFFF_FFFF);
        step(0, 4'd3, 0, 32'h5555_AAAA);
        step(0, 4'd3, 0, 32'h5555_AAAA);
        step(0, 4'd3, 0, 32'h5555_AAAA);
        // R8: all-ones write to the input register leaves the state alone
        @(negedge clk); held_lat = pin_out; held_dir = ~pin_oe;
        step(1, 4'd3, 32'hFFFF_FFFF, 32'h0);
        step(0, 4'd0, 0, 32'h0);
        @(negedge clk);
        check("R8 latch after input write", pin_out, held_lat);
        check("R8 direction after input write", ~pin_oe, held_dir);
        // R7: writes to unmapped addresses leave the state alone
        step(1, 4'd4, 32'hFFFF_FFFF, 32'h0);
        step(1, 4'd9, 32'hFFFF_FFFF, 32'h0);
        step(1, 4'd15, 32'h0, 32'h0);
        step(0, 4'd4, 0, 32'h0);
        @(negedge clk);
        check("R7 latch after unmapped write", pin_out, held_lat);
        check("R7 direction after unmapped write", ~pin_oe, held_dir);
        // Random traffic across all addresses
        for (int i = 0; i < 400; i++) begin
            lfsr = nxt(lfsr);
            step(lfsr[0], lfsr[4:1], nxt(lfsr) ^ {lfsr[15:0], lfsr[31:16]}, lfsr ^ 32'hC3C3_3C3C);
        end
        // R1: a second reset in mid-run
        rst_n = 1'b0;
        step(0, 4'd0, 0, 32'hFFFF_FFFF);
        step(0, 4'd3, 0, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        step(0, 4'd3, 0, 32'h0);
        step(0, 4'd1, 0, 32'h0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule